// File: doc/BRIEF.md
# Monitor Sense Line Sequencer

This block identifies an attached display by probing its three open-drain identification lines. A single-cycle start request sets off a fixed series of five windows. First all lines are pulled high briefly. Then all drivers are released. Then each line in turn is pulled low while the other two are observed. At the end of every settle window the three line levels are sampled, and selected bits are packed into an 11-bit identification code. When the series is complete, the lines are left released and a one-cycle done flag is raised.

The drive state is presented as a 6-bit word with two octal digits, one per control group, so that the pad logic can decode it directly. The three sampled levels arrive on a 3-bit input whose bits stand for register bits 8, 7 and 6 of the line status word. Both window lengths are cycle counts fixed by parameters.

Top module: `msense_seq`

## Requirements
- R1: While idle, a high `start` seen at a clock edge begins a sequence, and from that edge `drive_word` holds octal 07 (all lines driven high) for PRE_CYC cycles.
- R2: After the precharge window, `drive_word` steps through octal 77 (all released), 33 (first line low), 55 (second line low) and 66 (third line low), holding each for SETTLE_CYC cycles. No other word ever appears.
- R3: Each of the four settle windows samples `sense_lvl` only in its final cycle. Levels in earlier cycles of the window have no effect on the code.
- R4: The code is packed as follows. The released window puts `sense_lvl[2:0]` into code bits 10:8. The first-line-low window puts `sense_lvl[1:0]` into bits 5:4. The second-line-low window puts `sense_lvl[2]` into bit 3 and `sense_lvl[0]` into bit 2. The third-line-low window puts `sense_lvl[2:1]` into bits 1:0. Code bits 7:6 are always zero.
- R5: `done` is high for exactly one cycle. This cycle starts PRE_CYC+4*SETTLE_CYC cycles after the accepting edge, and `drive_word` is octal 77 during it.
- R6: `sense_code` changes only in the cycle where `done` is high, and otherwise holds its last value.
- R7: A `start` request that arrives during a sequence is ignored. It does not change the drive timing, the code or the number of done pulses.
- R8: During and after reset, `drive_word` is octal 77, `done` is low and `sense_code` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Request to begin a probe sequence |
| sense_lvl | input | 3 | Line levels as status bits 8,7,6 |
| drive_word | output | 6 | Octal-coded drive/tristate control |
| done | output | 1 | One-cycle completion pulse |
| sense_code | output | 11 | Packed identification code |

## Verification
The bench builds the block with PRE_CYC=2 and SETTLE_CYC=3. This keeps each sequence near seventeen cycles, so all 4096 combinations of the four 3-bit level sets can be swept. The line model returns the inverted level in every cycle of a window except its last. As a result, sampling one cycle early or late corrupts the code. Because the settle window is longer than one cycle, that sampling rule can actually be checked. In some sequences an extra start is injected mid-run, or in the final cycle of a window, to exercise R7.

// File: rtl/msense_pkg.sv
package msense_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_REL  = 3'd2,
    ST_ALO  = 3'd3,
    ST_BLO  = 3'd4,
    ST_CLO  = 3'd5
  } msense_step_e;

  localparam logic [5:0] DRV_HIGH = 6'o07;
  localparam logic [5:0] DRV_REL  = 6'o77;
  localparam logic [5:0] DRV_ALO  = 6'o33;
  localparam logic [5:0] DRV_BLO  = 6'o55;
  localparam logic [5:0] DRV_CLO  = 6'o66;

  localparam int CODE_W = 11;

  function automatic logic [5:0] drive_for(msense_step_e s);
    case (s)
      ST_PRE:  drive_for = DRV_HIGH;
      ST_ALO:  drive_for = DRV_ALO;
      ST_BLO:  drive_for = DRV_BLO;
      ST_CLO:  drive_for = DRV_CLO;
      default: drive_for = DRV_REL;
    endcase
  endfunction

endpackage

// File: rtl/msense_timer.sv
module msense_timer #(
  parameter int PRE_CYC    = 200,
  parameter int SETTLE_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic use_pre,
  output logic last
);
  localparam int MAXC  = (PRE_CYC > SETTLE_CYC) ? PRE_CYC : SETTLE_CYC;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] PRE_LIM = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] SET_LIM = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = restart | run;
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = run & (cnt_q == (use_pre ? PRE_LIM : SET_LIM));
endmodule

// File: rtl/msense_ctrl.sv
module msense_ctrl
  import msense_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         last,
  output msense_step_e step,
  output logic         busy,
  output logic         begin_seq,
  output logic         restart,
  output logic         finish,
  output logic         done
);
  msense_step_e state_q, state_d;
  logic         done_q;

  always_comb begin
    busy      = (state_q != ST_IDLE);
    begin_seq = ~busy & start;
    finish    = (state_q == ST_CLO) & last;
    restart   = begin_seq | last;
    state_d   = state_q;
    if (begin_seq) state_d = ST_PRE;
    else if (last) begin
      case (state_q)
        ST_PRE:  state_d = ST_REL;
        ST_REL:  state_d = ST_ALO;
        ST_ALO:  state_d = ST_BLO;
        ST_BLO:  state_d = ST_CLO;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
    end
  end

  assign step = state_q;
  assign done = done_q;
endmodule

// File: rtl/msense_pack.sv
module msense_pack
  import msense_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_seq,
  input  logic              take,
  input  logic              finish,
  input  msense_step_e      step,
  input  logic [2:0]        lvl,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] shadow_q, shadow_d, code_q;
  logic              shadow_en;

  always_comb begin
    shadow_d  = shadow_q;
    shadow_en = begin_seq | take;
    if (begin_seq) shadow_d = '0;
    else if (take) begin
      case (step)
        ST_REL: shadow_d[10:8] = lvl;
        ST_ALO: shadow_d[5:4]  = lvl[1:0];
        ST_BLO: shadow_d[3:2]  = {lvl[2], lvl[0]};
        ST_CLO: shadow_d[1:0]  = lvl[2:1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      code_q   <= '0;
    end else begin
      if (shadow_en) shadow_q <= shadow_d;
      if (finish)    code_q   <= shadow_d;
    end
  end

  assign code = code_q;
endmodule

// File: rtl/msense_seq.sv
module msense_seq
  import msense_pkg::*;
#(
  parameter int PRE_CYC    = 200,
  parameter int SETTLE_CYC = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  sense_lvl,
  output logic [5:0]  drive_word,
  output logic        done,
  output logic [10:0] sense_code
);
  msense_step_e step;
  logic busy, begin_seq, restart, finish, last;

  msense_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .last(last),
    .step(step), .busy(busy), .begin_seq(begin_seq),
    .restart(restart), .finish(finish), .done(done)
  );

  msense_timer #(.PRE_CYC(PRE_CYC), .SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(restart),
    .use_pre(step == ST_PRE), .last(last)
  );

  msense_pack u_pack (
    .clk(clk), .rst_n(rst_n), .begin_seq(begin_seq), .take(last),
    .finish(finish), .step(step), .lvl(sense_lvl), .code(sense_code)
  );

  assign drive_word = drive_for(step);
endmodule

// File: rtl/msense_seq_chk.sv
module msense_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [2:0]  sense_lvl,
  input logic [5:0]  drive_word,
  input logic        done,
  input logic [10:0] sense_code
);
  a_r2_drive_legal: assert property (@(posedge clk) disable iff (!rst_n)
    drive_word inside {6'o07, 6'o77, 6'o33, 6'o55, 6'o66});

  a_r2_after_alo: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drive_word) == 6'o33 && drive_word != 6'o33) |-> drive_word == 6'o55);

  a_r2_after_blo: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drive_word) == 6'o55 && drive_word != 6'o55) |-> drive_word == 6'o66);

  a_r2_after_clo: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drive_word) == 6'o66 && drive_word != 6'o66) |-> drive_word == 6'o77);

  a_r4_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sense_code[7:6] == 2'b00);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> drive_word == 6'o77);

  a_r6_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sense_code));

  logic unused_ok;
  assign unused_ok = ^{start, sense_lvl};
endmodule

bind msense_seq msense_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sense_lvl(sense_lvl),
  .drive_word(drive_word), .done(done), .sense_code(sense_code)
);

// File: tb/msense_seq_test.sv
module msense_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 2;
  localparam int SET = 3;
  localparam int TOT = PRE + 4 * SET;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  sense_lvl;
  logic [5:0]  drv;
  logic        done;
  logic [10:0] code;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [11:0] pat;
  logic [5:0]  prev_drv;
  logic [7:0]  age;
  logic [2:0]  tv;
  logic [7:0]  idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  msense_seq #(.PRE_CYC(PRE), .SETTLE_CYC(SET)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sense_lvl(sense_lvl),
    .drive_word(drv), .done(done), .sense_code(code)
  );

  // line model: true level only in the last cycle of a window
  always_ff @(posedge clk) begin
    prev_drv <= drv;
    if (drv != prev_drv) age <= 8'd1;
    else if (age != 8'hff) age <= age + 8'd1;
  end

  always_comb begin
    case (drv)
      6'o77:   tv = pat[11:9];
      6'o33:   tv = pat[8:6];
      6'o55:   tv = pat[5:3];
      6'o66:   tv = pat[2:0];
      default: tv = ~pat[2:0];
    endcase
    idx = (drv != prev_drv) ? 8'd0 : age;
    sense_lvl = (idx == 8'(SET - 1)) ? tv : ~tv;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] exp_drv(int i);
    if (i <= PRE) return 6'o07;
    case ((i - PRE - 1) / SET)
      0: return 6'o77;
      1: return 6'o33;
      2: return 6'o55;
      default: return 6'o66;
    endcase
  endfunction

  task automatic run_seq(input logic [11:0] p, input int inject, input logic [10:0] old_code);
    logic [10:0] exp;
    exp = {p[11:9], 2'b00, p[7:6], p[5], p[3], p[2:1]};
    @(negedge clk);
    pat = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= TOT; i++) begin
      check((i <= PRE) ? "R1 precharge word" : "R2 window word", drv, exp_drv(i));
      check("R5 no early done", done, 1'b0);
      check("R6 code held", code, old_code);
      start = (inject == i);
      @(negedge clk);
    end
    start = 1'b0;
    check((inject != 0) ? "R7 done timing with extra start" : "R5 done pulse", done, 1'b1);
    check("R5 released at done", drv, 6'o77);
    check("R3 R4 packed code", code, exp);
    @(negedge clk);
    check("R5 done one cycle", done, 1'b0);
    check("R7 stays idle", drv, 6'o77);
    check("R6 code kept", code, exp);
  endtask

  initial begin
    logic [10:0] cur;
    rst_n = 1'b0;
    start = 1'b0;
    pat = '0;
    prev_drv = 6'o77;
    age = 8'd0;
    repeat (3) @(negedge clk);
    check("R8 reset drive", drv, 6'o77);
    check("R8 reset done", done, 1'b0);
    check("R8 reset code", code, 11'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", drv, 6'o77);
    cur = '0;
    for (int k = 0; k < 4096; k++) begin
      int inj;
      logic [11:0] p;
      p = 12'(k);
      inj = (k % 7 == 3) ? 4 : ((k % 11 == 5) ? TOT : ((k % 13 == 1) ? PRE : 0));
      run_seq(p, inj, cur);
      cur = {p[11:9], 2'b00, p[7:6], p[5], p[3], p[2:1]};
    end
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule